// File: doc/BRIEF.md
# Global 64-bit Counter with Event Comparator

This block holds a 64-bit up-counter that runs freely once started. Next to it sits a single 64-bit comparator that raises a level interrupt when the counter equals the programmed compare value. In one-shot use the comparator fires once and then waits to be re-armed. In periodic use it adds a programmed step to its own compare value on every match, so events repeat at a fixed interval without any software action.

Software reaches the block through a plain 32-bit register port. Writes complete in one clock, and reads are combinational. The 64-bit counter and compare values are loaded one 32-bit half at a time. Each writable register has a sticky "write done" flag that software clears by writing 1 to it. The comparator is a three-state machine:
- OFF: the comparator is disabled.
- ARMED: the comparator watches for a match.
- SPENT: a one-shot match has already fired.

Its transitions are:
- OFF to ARMED, one clock after the enable bit is set.
- ARMED to SPENT, on a match in one-shot mode.
- ARMED stays ARMED on a match in periodic mode, and the compare value advances.
- SPENT to ARMED, when either compare half is written.
- ARMED or SPENT to OFF, when the enable bit is cleared.

Top module: `global_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the counter holds at zero.
- R2: While CTRL (0x20) bit 0 is set, the counter adds one per clock, and a carry out of the low half reaches the high half in the same clock. While bit 0 is clear, the counter holds its value.
- R3: A write to COUNT_LO (0x00) or COUNT_HI (0x04) replaces only that half. A write takes priority over the increment in its cycle.
- R4: With CTRL bit 1 set and the comparator armed, a cycle in which the counter equals the compare value (COMPARE_LO 0x10, COMPARE_HI 0x14) sets PENDING (0x24) bit 0 at the clock edge that ends that cycle. While the counter is running, it reads compare+1 in the first cycle after that edge. The comparator arms one clock after CTRL bit 1 is set.
- R5: With CTRL bit 2 set, each match adds STEP (0x18) to the 64-bit compare value at the match edge, so matches repeat every STEP clocks.
- R6: With CTRL bit 2 clear, a match leaves the comparator SPENT. Moving the counter back below the compare value gives no second match. Writing either compare half re-arms the comparator.
- R7: Writing 1 to PENDING bit 0 clears it. Writing 0 has no effect. A match in the same cycle as a clear wins.
- R8: `irq` is high exactly when PENDING bit 0 and MASK (0x28) bit 0 are both set. A match with MASK clear still sets PENDING.
- R9: WDONE (0x2C) has one sticky flag per register, set by a write to it:
  - bit 0 for COMPARE_LO;
  - bit 1 for COMPARE_HI;
  - bit 2 for STEP;
  - bit 3 for CTRL.

  COUNT_DONE (0x08) has bit 0 for COUNT_LO and bit 1 for COUNT_HI. Each flag is visible from the clock after its write and stays set until 1 is written to it.
- R10: Addresses not listed above read zero, and writes to them change nothing.
- R11: With CTRL bit 1 clear no match occurs, even when the counter passes the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; zero when not selected |
| irq | output | 1 | Level interrupt |

## Verification
The hardest condition to reach is the SPENT state, with the counter moved back below the compare value it has already matched. Without SPENT tracking, the design would fire a second time there. The stimulus fires a one-shot match, clears the pending flag, then reloads the counter low half to a value under the compare value and lets it run past that value again. The bench then expects silence. After that it rewrites the compare value and expects a fresh match at the computed count.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CNT_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] A_CNT_DONE = 8'h08;
    localparam logic [ADDR_W-1:0] A_CMP_LO   = 8'h10;
    localparam logic [ADDR_W-1:0] A_CMP_HI   = 8'h14;
    localparam logic [ADDR_W-1:0] A_STEP     = 8'h18;
    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h20;
    localparam logic [ADDR_W-1:0] A_PEND     = 8'h24;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h28;
    localparam logic [ADDR_W-1:0] A_DONE     = 8'h2C;

    // Control bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_AUTO = 2;
    localparam int CTL_W    = 3;

    typedef enum logic [1:0] {
        CS_OFF   = 2'd0,
        CS_ARMED = 2'd1,
        CS_SPENT = 2'd2
    } cmp_state_t;
endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_lo || load_hi) begin
            if (load_lo) count[DATA_W-1:0]     <= wdata;
            if (load_hi) count[CNT_W-1:DATA_W] <= wdata;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/gtmr_cmp.sv
module gtmr_cmp
    import gtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              auto_step,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              load_step,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [DATA_W-1:0] step_val,
    output logic              hit,
    output cmp_state_t        state
);
    cmp_state_t state_nx;
    logic       reload;

    assign reload = load_lo || load_hi;

    // Output process
    always_comb begin
        hit = 1'b0;
        unique case (state)
            CS_ARMED: hit = enable && (count == cmp_val);
            CS_OFF, CS_SPENT: hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end

    // Next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_OFF:   if (enable) state_nx = CS_ARMED;
            CS_ARMED: begin
                if (!enable)                           state_nx = CS_OFF;
                else if (hit && !auto_step && !reload) state_nx = CS_SPENT;
            end
            CS_SPENT: begin
                if (!enable)     state_nx = CS_OFF;
                else if (reload) state_nx = CS_ARMED;
            end
            default: state_nx = CS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val  <= '0;
            step_val <= '0;
        end else begin
            if (load_step) step_val <= wdata;
            if (reload) begin
                if (load_lo) cmp_val[DATA_W-1:0]     <= wdata;
                if (load_hi) cmp_val[CNT_W-1:DATA_W] <= wdata;
            end else if (hit && auto_step) begin
                cmp_val <= cmp_val + CNT_W'(step_val);
            end
        end
    end
endmodule

// File: rtl/gtmr_regs.sv
module gtmr_regs
    import gtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hit,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [DATA_W-1:0] step_val,
    output logic [CTL_W-1:0]  ctrl,
    output logic              wr_cnt_lo,
    output logic              wr_cnt_hi,
    output logic              wr_cmp_lo,
    output logic              wr_cmp_hi,
    output logic              wr_step,
    output logic              wr_done,
    output logic              pend,
    output logic              mask,
    output logic [3:0]        wdone,
    output logic [1:0]        cnt_done,
    output logic              irq
);
    logic wr_any, wr_ctrl, wr_pend, wr_mask, wr_cdone;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:4];

    assign wr_any    = bus_sel && bus_wr;
    assign wr_cnt_lo = wr_any && (bus_addr == A_CNT_LO);
    assign wr_cnt_hi = wr_any && (bus_addr == A_CNT_HI);
    assign wr_cdone  = wr_any && (bus_addr == A_CNT_DONE);
    assign wr_cmp_lo = wr_any && (bus_addr == A_CMP_LO);
    assign wr_cmp_hi = wr_any && (bus_addr == A_CMP_HI);
    assign wr_step   = wr_any && (bus_addr == A_STEP);
    assign wr_ctrl   = wr_any && (bus_addr == A_CTRL);
    assign wr_pend   = wr_any && (bus_addr == A_PEND);
    assign wr_mask   = wr_any && (bus_addr == A_MASK);
    assign wr_done   = wr_any && (bus_addr == A_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            mask     <= 1'b0;
            pend     <= 1'b0;
            wdone    <= '0;
            cnt_done <= '0;
        end else begin
            if (wr_ctrl) ctrl <= bus_wdata[CTL_W-1:0];
            if (wr_mask) mask <= bus_wdata[0];
            pend  <= hit || (pend && !(wr_pend && bus_wdata[0]));
            wdone <= (wdone & ~(wr_done ? bus_wdata[3:0] : 4'b0))
                   | {wr_ctrl, wr_step, wr_cmp_hi, wr_cmp_lo};
            cnt_done <= (cnt_done & ~(wr_cdone ? bus_wdata[1:0] : 2'b0))
                      | {wr_cnt_hi, wr_cnt_lo};
        end
    end

    assign irq = pend && mask;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (bus_addr)
                A_CNT_LO:   bus_rdata = count[DATA_W-1:0];
                A_CNT_HI:   bus_rdata = count[CNT_W-1:DATA_W];
                A_CNT_DONE: bus_rdata[1:0] = cnt_done;
                A_CMP_LO:   bus_rdata = cmp_val[DATA_W-1:0];
                A_CMP_HI:   bus_rdata = cmp_val[CNT_W-1:DATA_W];
                A_STEP:     bus_rdata = step_val;
                A_CTRL:     bus_rdata[CTL_W-1:0] = ctrl;
                A_PEND:     bus_rdata[0] = pend;
                A_MASK:     bus_rdata[0] = mask;
                A_DONE:     bus_rdata[3:0] = wdone;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/global_timer.sv
module global_timer
    import gtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CTL_W-1:0]  ctrl;
    logic              wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_step, wr_done;
    logic              pend, mask, hit;
    logic [3:0]        wdone;
    logic [1:0]        cnt_done;
    logic [CNT_W-1:0]  count, cmp_val;
    logic [DATA_W-1:0] step_val;
    cmp_state_t        cmp_state;
    logic              cnt_load, cmp_load;

    assign cnt_load = wr_cnt_lo || wr_cnt_hi;
    assign cmp_load = wr_cmp_lo || wr_cmp_hi;

    gtmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hit(hit), .count(count), .cmp_val(cmp_val), .step_val(step_val),
        .ctrl(ctrl),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
        .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi),
        .wr_step(wr_step), .wr_done(wr_done),
        .pend(pend), .mask(mask), .wdone(wdone), .cnt_done(cnt_done),
        .irq(irq)
    );

    gtmr_counter #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(ctrl[CTL_RUN]),
        .load_lo(wr_cnt_lo), .load_hi(wr_cnt_hi), .wdata(bus_wdata),
        .count(count)
    );

    gtmr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl[CTL_EN]), .auto_step(ctrl[CTL_AUTO]),
        .load_lo(wr_cmp_lo), .load_hi(wr_cmp_hi), .load_step(wr_step),
        .wdata(bus_wdata), .count(count),
        .cmp_val(cmp_val), .step_val(step_val), .hit(hit), .state(cmp_state)
    );
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cmp_en,
    input logic              auto_step,
    input logic              cnt_load,
    input logic              cmp_load,
    input logic              hit,
    input logic              pend,
    input logic              wr_done,
    input logic [3:0]        wdone,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp_val,
    input logic [DATA_W-1:0] step_val
);
    AST_CNT_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cnt_load |=> count == $past(count) + 1'b1); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_load |=> count == $past(count)); // R2
    AST_MATCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend); // R4
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        hit && auto_step && !cmp_load |=> cmp_val == $past(cmp_val) + CNT_W'($past(step_val))); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> (wdone & $past(wdone)) == $past(wdone)); // R9
    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> !hit); // R11
endmodule

bind global_timer gtmr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl[0]), .cmp_en(ctrl[1]), .auto_step(ctrl[2]),
    .cnt_load(cnt_load), .cmp_load(cmp_load),
    .hit(hit), .pend(pend), .wr_done(wr_done), .wdone(wdone),
    .count(count), .cmp_val(cmp_val), .step_val(step_val)
);

// File: tb/global_timer_tb.sv
module global_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    global_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; commits at the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read without a clock edge
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic poll_irq(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (irq) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic poll_pend(input int limit, output bit seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            rd(8'h24, v);
            if (v[0]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        logic [7:0] addrs [10] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14,
                                   8'h18, 8'h20, 8'h24, 8'h28, 8'h2C};
        for (int i = 0; i < 10; i++) begin
            rd(addrs[i], v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        repeat (5) @(negedge clk);
        rd(8'h00, v);
        check("R1 counter held", v, 32'h0);
    endtask

    task automatic t_done;
        logic [31:0] v;
        wr(8'h14, 32'h0);
        rd(8'h2C, v); check("R9 compare-high flag", v, 32'h2);
        wr(8'h18, 32'd7);
        rd(8'h2C, v); check("R9 step flag", v, 32'h6);
        wr(8'h2C, 32'h2);
        rd(8'h2C, v); check("R9 clear one flag", v, 32'h4);
        wr(8'h2C, 32'h0);
        rd(8'h2C, v); check("R9 write zero keeps", v, 32'h4);
        wr(8'h2C, 32'h4);
        rd(8'h2C, v); check("R9 all clear", v, 32'h0);
        wr(8'h00, 32'h0);
        rd(8'h08, v); check("R9 count-low flag", v, 32'h1);
        wr(8'h08, 32'h1);
        rd(8'h08, v); check("R9 count flag clear", v, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h04, 32'h5);
        rd(8'h00, v); check("R3 load low", v, 32'hFFFF_FFFE);
        rd(8'h04, v); check("R3 load high", v, 32'h5);
        wr(8'h20, 32'h1);
        repeat (3) @(negedge clk);
        rd(8'h04, v); check("R2 carry high", v, 32'h6);
        rd(8'h00, v); check("R2 carry low", v, 32'h1);
        wr(8'h20, 32'h0);  // one more increment lands on the commit edge
        repeat (4) @(negedge clk);
        rd(8'h00, v); check("R2 stopped hold", v, 32'h2);
        wr(8'h20, 32'h1);
        wr(8'h00, 32'h100);
        rd(8'h00, v); check("R3 write beats increment", v, 32'h100);
        rd(8'h04, v); check("R3 high untouched", v, 32'h6);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        bit seen;
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h28, 32'h1);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'd40);
        wr(8'h20, 32'h3);
        poll_irq(200, seen);
        check("R4 match seen", {31'b0, seen}, 32'h1);
        rd(8'h00, v); check("R4 count at first irq", v, 32'd41);
        wr(8'h24, 32'h0);
        rd(8'h24, v); check("R7 write zero keeps pending", v, 32'h1);
        wr(8'h24, 32'h1);
        rd(8'h24, v); check("R7 clear pending", v, 32'h0);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'd30);
        repeat (30) @(negedge clk);
        rd(8'h24, v); check("R6 spent no refire", v, 32'h0);
        rd(8'h00, v);
        wr(8'h10, v + 32'd20);
        poll_irq(200, seen);
        check("R6 rearm match", {31'b0, seen}, 32'h1);
        rd(8'h00, bus_wdata);
        check("R6 rearm count", bus_wdata, v + 32'd21);
        wr(8'h24, 32'h1);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        bit seen;
        wr(8'h28, 32'h0);
        rd(8'h00, v);
        wr(8'h10, v + 32'd20);
        poll_pend(200, seen);
        check("R8 pending with mask clear", {31'b0, seen}, 32'h1);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'h1);
        check("R8 irq after unmask", {31'b0, irq}, 32'h1);
        wr(8'h24, 32'h1);
    endtask

    task automatic t_disable;
        logic [31:0] v, c;
        bit seen;
        wr(8'h20, 32'h1);
        wr(8'h24, 32'h1);
        rd(8'h00, v);
        wr(8'h10, v + 32'd10);
        repeat (40) @(negedge clk);
        rd(8'h24, c); check("R11 disabled no match", c, 32'h0);
        rd(8'h00, v);
        wr(8'h10, v + 32'd30);
        wr(8'h20, 32'h3);
        poll_irq(200, seen);
        check("R11 re-enabled match", {31'b0, seen}, 32'h1);
        rd(8'h00, c); check("R11 count at match", c, v + 32'd31);
        wr(8'h24, 32'h1);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        bit seen;
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h18, 32'd25);
        wr(8'h10, 32'd50);
        wr(8'h20, 32'h7);
        poll_irq(200, seen);
        rd(8'h00, v); check("R5 first periodic count", v, 32'd51);
        rd(8'h10, v); check("R5 compare advanced", v, 32'd75);
        wr(8'h24, 32'h1);
        poll_irq(200, seen);
        rd(8'h00, v); check("R5 second periodic count", v, 32'd76);
        rd(8'h10, v); check("R5 compare advanced again", v, 32'd100);
        wr(8'h24, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, v); check("R10 unmapped reads zero", v, 32'h0);
        rd(8'h20, v); check("R10 control untouched", v, 32'h7);
        rd(8'h28, v); check("R10 mask untouched", v, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_done();
        t_count();
        t_oneshot();
        t_mask();
        t_disable();
        t_periodic();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule